// File: doc/BRIEF.md
# Microcoded Accumulator CPU Core

This block is a small 8-bit accumulator processor with a 16-location address space. One shared data bus connects its registers. A step sequencer and a combinational microcode decoder drive that bus. Every instruction byte carries an opcode in its upper four bits and an operand or address in its lower four bits. Each instruction first spends two steps on fetch. It then runs only as many execute steps as it needs. A done bit in the control word sends the sequencer back to fetch straight away, so each instruction takes its own number of cycles.

The block holds a program counter, a memory address register, an instruction register, an accumulator A, an operand register B, an adder/subtractor, a one-bit carry flag and an output register. The program and data memory is a synchronous array that updates on the falling clock edge. A read address set up on a rising edge therefore returns its data before the next rising edge. A host loads the memory through a write port while the core is held in reset. The core then runs on every rising edge where `run_en` is high, until it executes a halt. The output register, a halted flag and the live control word are brought out for observation.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, address register, instruction register, A, B, carry, output register, step counter and halted flag, so `out_value` reads 0 and `halted` reads 0.
- R2: An instruction byte is opcode (bits 7:4) and operand (bits 3:0). Fetch drives the program counter into the address register, then loads the instruction register from memory and increments the counter. LDA (0x1m) loads A from memory location m, OUT (0xE0) copies A to `out_value`, and at most one source drives the bus at a time.
- R3: ADD (0x2m) sets A to (A + mem[m]) modulo 256.
- R4: SUB (0x3m) sets A to (A + ~mem[m] + 1) modulo 256.
- R5: ADD sets the carry flag to the adder carry-out. JCS (0x7m) loads the program counter with m when carry is 1.
- R6: SUB sets carry to the adder carry-out: 1 when A >= mem[m] (no borrow), 0 otherwise.
- R7: LDI (0x5n) loads A with n zero-extended to 8 bits.
- R8: STA (0x4m) writes A to memory location m, and a later LDA of m returns that value.
- R9: JMP (0x6m) continues execution at location m.
- R10: Only ADD and SUB change the carry flag. JCS with carry 0 falls through to the next location.
- R11: Counted in enabled clock cycles, NOP, LDI, JMP, JCS, OUT and HLT take 3, LDA and STA take 4, and ADD and SUB take 5. The step following a control word whose done bit (`ctrl_word` bit 0) is set is step 0.
- R12: Opcodes 0x0 and 0x8 through 0xD change no register other than the program counter and take 3 cycles.
- R13: HLT (0xF0) sets `halted` at the end of its third cycle. From then until reset, `out_value` and all other state stay unchanged and `ctrl_word` reads all zeros.
- R14: In a cycle with `run_en` low no register changes, so a program gives the same result and the same count of enabled cycles however its cycles are gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; memory updates on the falling edge |
| rst | input | 1 | Synchronous active-high reset of the core state |
| run_en | input | 1 | Clock enable for the core |
| load_we | input | 1 | Memory write strobe for preloading |
| load_addr | input | ADDR_W | Memory location written by the load port |
| load_data | input | DATA_W | Byte written by the load port |
| out_value | output | DATA_W | Output register |
| halted | output | 1 | High once HLT has executed |
| ctrl_word | output | 17 | Current microcode control word (bit 0 done, bit 1 halt), zero while halted |

## Verification
The bench builds the core with its default 8-bit data and 4-bit address widths. At these widths it can fill the whole 16-byte memory for every program, and it can reach every opcode value in the upper nibble. Operand pairs such as 200+100 and 20-50 drive the 8-bit adder through its wrap and borrow cases, and the carry result is made visible by taken and untaken conditional jumps. A scoreboard compares the final output and the enabled-cycle count at each halt. The count makes the per-opcode step lengths observable from outside, and a gated rerun shows that the enable has no effect on the result.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W     = 4;
  localparam int STEP_W    = 3;
  localparam int MAX_STEPS = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP = 4'h0,
    OP_LDA = 4'h1,
    OP_ADD = 4'h2,
    OP_SUB = 4'h3,
    OP_STA = 4'h4,
    OP_LDI = 4'h5,
    OP_JMP = 4'h6,
    OP_JCS = 4'h7,
    OP_OUT = 4'hE,
    OP_HLT = 4'hF
  } opcode_e;

  // First member is the most significant bit: done ends up at bit 0, halt at bit 1.
  typedef struct packed {
    logic pc_oe;
    logic pc_inc;
    logic pc_ld;
    logic mar_ld;
    logic ram_oe;
    logic ram_wr;
    logic ir_oe;
    logic ir_ld;
    logic a_oe;
    logic a_ld;
    logic b_ld;
    logic alu_oe;
    logic alu_sub;
    logic cy_ld;
    logic out_ld;
    logic halt;
    logic done;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/acc_cpu_ucode.sv
module acc_cpu_ucode
  import acc_cpu_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [STEP_W-1:0] step,
  input  logic              carry,
  output ctrl_t             ctrl
);

  opcode_e op;
  assign op = opcode_e'(opcode);

  always_comb begin
    ctrl = '0;
    case (step)
      3'd0: begin
        ctrl.pc_oe  = 1'b1;
        ctrl.mar_ld = 1'b1;
      end
      3'd1: begin
        ctrl.ram_oe = 1'b1;
        ctrl.ir_ld  = 1'b1;
        ctrl.pc_inc = 1'b1;
      end
      3'd2: begin
        case (op)
          OP_LDA, OP_ADD, OP_SUB, OP_STA: begin
            ctrl.ir_oe  = 1'b1;
            ctrl.mar_ld = 1'b1;
          end
          OP_LDI: begin
            ctrl.ir_oe = 1'b1;
            ctrl.a_ld  = 1'b1;
            ctrl.done  = 1'b1;
          end
          OP_JMP: begin
            ctrl.ir_oe = 1'b1;
            ctrl.pc_ld = 1'b1;
            ctrl.done  = 1'b1;
          end
          OP_JCS: begin
            ctrl.ir_oe = carry;
            ctrl.pc_ld = carry;
            ctrl.done  = 1'b1;
          end
          OP_OUT: begin
            ctrl.a_oe   = 1'b1;
            ctrl.out_ld = 1'b1;
            ctrl.done   = 1'b1;
          end
          OP_HLT: ctrl.halt = 1'b1;
          default: ctrl.done = 1'b1;
        endcase
      end
      3'd3: begin
        case (op)
          OP_LDA: begin
            ctrl.ram_oe = 1'b1;
            ctrl.a_ld   = 1'b1;
            ctrl.done   = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            ctrl.ram_oe = 1'b1;
            ctrl.b_ld   = 1'b1;
          end
          OP_STA: begin
            ctrl.a_oe   = 1'b1;
            ctrl.ram_wr = 1'b1;
            ctrl.done   = 1'b1;
          end
          default: ctrl.done = 1'b1;
        endcase
      end
      3'd4: begin
        ctrl.done = 1'b1;
        if (op == OP_ADD || op == OP_SUB) begin
          ctrl.alu_oe  = 1'b1;
          ctrl.alu_sub = (op == OP_SUB);
          ctrl.a_ld    = 1'b1;
          ctrl.cy_ld   = 1'b1;
        end
      end
      default: ctrl.done = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              step_done,
  input  logic              step_halt,
  output logic [STEP_W-1:0] step,
  output logic              halted,
  output logic              active
);

  assign active = run_en & ~halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= '0;
      halted <= 1'b0;
    end else if (active) begin
      if (step_halt) begin
        halted <= 1'b1;
        step   <= '0;
      end else if (step_done) begin
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

endmodule

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Falling-edge array: an address set on a rising edge has data before the next one.
  always_ff @(negedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] bus,
  output logic [ADDR_W-1:0] mar,
  output logic [OPC_W-1:0]  opcode,
  output logic              carry,
  output logic [DATA_W-1:0] out_value
);

  localparam int OPD_W = DATA_W - OPC_W;
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;
  logic [DATA_W:0]   alu_full;

  function automatic logic [DATA_W:0] alu_calc(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic              sub);
    logic [DATA_W:0] xe;
    logic [DATA_W:0] ye;
    xe = {1'b0, x};
    ye = {1'b0, (sub ? ~y : y)};
    return xe + ye + {{DATA_W{1'b0}}, sub};
  endfunction

  assign alu_full = alu_calc(a_q, b_q, ctrl.alu_sub);
  assign opcode   = ir[DATA_W-1 -: OPC_W];

  always_comb begin
    bus = '0;
    if (ctrl.pc_oe)       bus = {{PAD_W{1'b0}}, pc};
    else if (ctrl.ram_oe) bus = ram_rdata;
    else if (ctrl.ir_oe)  bus = {{OPC_W{1'b0}}, ir[OPD_W-1:0]};
    else if (ctrl.a_oe)   bus = a_q;
    else if (ctrl.alu_oe) bus = alu_full[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      mar       <= '0;
      ir        <= '0;
      a_q       <= '0;
      b_q       <= '0;
      carry     <= 1'b0;
      out_value <= '0;
    end else if (active) begin
      if (ctrl.pc_ld)       pc <= bus[ADDR_W-1:0];
      else if (ctrl.pc_inc) pc <= pc + 1'b1;
      if (ctrl.mar_ld) mar       <= bus[ADDR_W-1:0];
      if (ctrl.ir_ld)  ir        <= bus;
      if (ctrl.a_ld)   a_q       <= bus;
      if (ctrl.b_ld)   b_q       <= bus;
      if (ctrl.out_ld) out_value <= bus;
      if (ctrl.cy_ld)  carry     <= alu_full[DATA_W];
    end
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              load_we,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] out_value,
  output logic              halted,
  output logic [CTRL_W-1:0] ctrl_word
);

  ctrl_t             ctrl;
  logic [STEP_W-1:0] step;
  logic              active;
  logic [OPC_W-1:0]  opcode;
  logic              carry;
  logic [DATA_W-1:0] bus;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] ram_rdata;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  acc_cpu_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .step_done (ctrl.done),
    .step_halt (ctrl.halt),
    .step      (step),
    .halted    (halted),
    .active    (active)
  );

  acc_cpu_ucode u_ucode (
    .opcode (opcode),
    .step   (step),
    .carry  (carry),
    .ctrl   (ctrl)
  );

  acc_cpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .ctrl      (ctrl),
    .ram_rdata (ram_rdata),
    .bus       (bus),
    .mar       (mar),
    .opcode    (opcode),
    .carry     (carry),
    .out_value (out_value)
  );

  // The load port wins over a store from the core.
  assign ram_we    = load_we | (active & ctrl.ram_wr);
  assign ram_waddr = load_we ? load_addr : mar;
  assign ram_wdata = load_we ? load_data : bus;

  acc_cpu_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (mar),
    .rdata (ram_rdata)
  );

  assign ctrl_word = halted ? '0 : ctrl;

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              active,
  input logic              halted,
  input logic [STEP_W-1:0] step,
  input ctrl_t             ctrl,
  input logic              carry,
  input logic [DATA_W-1:0] out_value
);

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst) 32'(step) < MAX_STEPS); // R11
  AST_DONE_RESTART: assert property (@(posedge clk) disable iff (rst) active && ctrl.done |=> step == '0); // R11
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst) active && !ctrl.done && !ctrl.halt |=> step == $past(step) + 1'b1); // R11
  AST_BUS_SINGLE: assert property (@(posedge clk) disable iff (rst) $onehot0({ctrl.pc_oe, ctrl.ram_oe, ctrl.ir_oe, ctrl.a_oe, ctrl.alu_oe})); // R2
  AST_CARRY_SOURCE: assert property (@(posedge clk) disable iff (rst) !(active && ctrl.cy_ld) |=> $stable(carry)); // R10
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst) active && ctrl.halt |=> halted); // R13
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted && $stable(out_value) && $stable(carry)); // R13
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst) !run_en |=> $stable(out_value) && $stable(carry) && $stable(step)); // R14

endmodule

bind acc_cpu_core acc_cpu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run_en    (run_en),
  .active    (active),
  .halted    (halted),
  .step      (step),
  .ctrl      (ctrl),
  .carry     (carry),
  .out_value (out_value)
);

// File: tb/test_acc_cpu_core.sv
`timescale 1ns/1ps
module test_acc_cpu_core;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int CW     = 17;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en_req = 1'b0;
  logic              gate = 1'b0;
  logic              tog = 1'b0;
  logic              run_en;
  logic              load_we = 1'b0;
  logic [ADDR_W-1:0] load_addr = '0;
  logic [DATA_W-1:0] load_data = '0;
  logic [DATA_W-1:0] out_value;
  logic              halted;
  logic [CW-1:0]     ctrl_word;

  always #5 clk = ~clk;

  acc_cpu_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_acc_cpu_core (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .load_we   (load_we),
    .load_addr (load_addr),
    .load_data (load_data),
    .out_value (out_value),
    .halted    (halted),
    .ctrl_word (ctrl_word)
  );

  always @(posedge clk) tog <= ~tog;
  assign run_en = en_req & (~gate | tog);

  // Enabled cycles since reset release, up to and including the halting edge.
  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else if (run_en && !halted) cyc <= cyc + 1;
  end

  typedef struct {
    string            req;
    logic [DATA_W-1:0] out;
    int               cycles;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  logic [DATA_W-1:0] prog [16];

  task automatic check(input string req, input string what, input logic ok,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expectation when the core halts.
  initial begin
    logic prev_h;
    exp_t e;
    prev_h = 1'b0;
    forever begin
      @(negedge clk);
      if (halted && !prev_h) begin
        if (sb_q.size() == 0) begin
          check("R13", "unexpected halt", 1'b0, 1, 0);
        end else begin
          e = sb_q.pop_front();
          check(e.req, "output", out_value == e.out, int'(out_value), int'(e.out));
          check({e.req, " R11"}, "cycles", cyc == e.cycles, cyc, e.cycles);
        end
      end
      prev_h = halted;
    end
  end

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
  endtask

  task automatic run_prog(input string req, input logic [DATA_W-1:0] exp_out,
                          input int exp_cyc, input logic gated);
    logic [DATA_W-1:0] held;
    @(posedge clk); #1;
    rst = 1'b1; en_req = 1'b0; gate = 1'b0;
    for (int i = 0; i < 16; i++) begin
      load_we = 1'b1; load_addr = i[ADDR_W-1:0]; load_data = prog[i];
      @(posedge clk); #1;
    end
    load_we = 1'b0;
    @(posedge clk); #1;
    check("R1", "reset out_value", out_value == '0, int'(out_value), 0);
    check("R1", "reset halted", halted == 1'b0, int'(halted), 0);
    sb_q.push_back('{req, exp_out, exp_cyc});
    gate = gated; en_req = 1'b1; rst = 1'b0;
    for (int k = 0; k < 400 && !halted; k++) @(negedge clk);
    if (!halted) check({req, " R13"}, "halt reached", 1'b0, 0, 1);
    @(negedge clk);
    held = out_value;
    repeat (6) @(negedge clk);
    check("R13", "halted stays", halted == 1'b1, int'(halted), 1);
    check("R13", "output frozen", out_value == held, int'(out_value), int'(held));
    check("R13", "ctrl_word zero", ctrl_word == '0, int'(ctrl_word), 0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R2 R3 R11: LDA, ADD, OUT, HLT -> 24+18
    clear_prog();
    prog[0] = 8'h1E; prog[1] = 8'h2F; prog[2] = 8'hE0; prog[3] = 8'hF0;
    prog[14] = 8'd24; prog[15] = 8'd18;
    run_prog("R2 R3", 8'd42, 15, 1'b0);

    // R4 R6 R5: 50-20 sets carry (no borrow), JCS taken to LDI 7
    clear_prog();
    prog[0] = 8'h1E; prog[1] = 8'h3F; prog[2] = 8'hE0; prog[3] = 8'h75;
    prog[4] = 8'hF0; prog[5] = 8'h57; prog[6] = 8'hE0; prog[7] = 8'hF0;
    prog[14] = 8'd50; prog[15] = 8'd20;
    run_prog("R4 R6 R5", 8'd7, 24, 1'b0);

    // R4 R6 R10: 20-50 wraps to 226, borrow clears carry, JCS falls through
    prog[14] = 8'd20; prog[15] = 8'd50;
    run_prog("R4 R6 R10", 8'd226, 18, 1'b0);

    // R3 R5 R10: 200+100 wraps to 44 with carry; LDI keeps carry; JCS taken
    clear_prog();
    prog[0] = 8'h1E; prog[1] = 8'h2F; prog[2] = 8'h53; prog[3] = 8'h75;
    prog[4] = 8'hF0; prog[5] = 8'hE0; prog[6] = 8'hF0;
    prog[14] = 8'd200; prog[15] = 8'd100;
    run_prog("R3 R5 R10", 8'd3, 21, 1'b0);

    // R7 R8: A=0xFF, LDI 9 (zero-extended), STA 13, LDA 15, LDA 13, OUT
    clear_prog();
    prog[0] = 8'h1E; prog[1] = 8'h59; prog[2] = 8'h4D; prog[3] = 8'h1F;
    prog[4] = 8'h1D; prog[5] = 8'hE0; prog[6] = 8'hF0;
    prog[14] = 8'hFF; prog[15] = 8'h11;
    run_prog("R7 R8", 8'd9, 25, 1'b0);

    // R9 R12: LDI 5, unused 0x8F, JMP 4 over HLT, unused 0xD3, OUT, NOP, HLT
    clear_prog();
    prog[0] = 8'h55; prog[1] = 8'h8F; prog[2] = 8'h64; prog[3] = 8'hF0;
    prog[4] = 8'hD3; prog[5] = 8'hE0; prog[6] = 8'h00; prog[7] = 8'hF0;
    run_prog("R9 R12", 8'd5, 21, 1'b0);

    // R14: first program again with run_en low on every other cycle
    clear_prog();
    prog[0] = 8'h1E; prog[1] = 8'h2F; prog[2] = 8'hE0; prog[3] = 8'hF0;
    prog[14] = 8'd24; prog[15] = 8'd18;
    run_prog("R14", 8'd42, 15, 1'b1);

    repeat (3) @(negedge clk);
    check("R2", "scoreboard drained", sb_q.size() == 0, sb_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule